// File: doc/BRIEF.md
# Interrupt Acceptance and Mode Controller

This block keeps the interrupt-enable state of an 8-bit processor core and decides, cycle by cycle, whether a pending interrupt request is taken and what the core must do about it. It holds two enable flip-flops. The first gates maskable requests. The second keeps a copy of the earlier enable state, so that a return from a non-maskable handler can restore it. It also holds a two-bit response mode that the core's decoder sets.

The core drives one-cycle decode strobes for enable, disable, set-mode, return-from-handler and load-accumulator-from-vector/refresh. It also supplies the maskable request, the non-maskable request, the byte placed on the bus by the interrupting device and the current vector-base register. When a request is taken, the block raises a registered one-clock accept pulse. Alongside it comes an action code: execute the device byte as an opcode, restart at a fixed address, or jump through a vector built from the base register and the device byte. The block also gives the target address, a push-PC request and the machine-cycle cost. The core performs the fetch, the stack write and the jump itself.

Top module: `int_accept_ctrl`

## Requirements
- R1: A maskable request (`int_req` high in a cycle) is taken only if the primary enable flag is set in that cycle and no non-maskable request is taken in that cycle. Otherwise no accept pulse follows.
- R2: Taking a maskable request clears both enable flags.
- R3: A non-maskable request is taken on every rising edge of `nmi_req`, whatever the enable flags hold. It clears the primary flag and leaves the backup flag unchanged. It reports action 01 (restart), target 0x0066, `push_pc`=1 and 13 cycles.
- R4: A maskable request taken in mode 0 reports action 00 (execute device byte), target {0x00, device byte}, `push_pc`=0 and 0 cycles, because the executed opcode sets the cost.
- R5: A maskable request taken in mode 1 reports action 01, target 0x0038, `push_pc`=1 and 13 cycles.
- R6: A maskable request taken in mode 2 reports action 10 (vectored), target {`vec_base`, device byte}, `push_pc`=1 and 19 cycles.
- R7: When a non-maskable edge and a maskable request fall in the same cycle, only the non-maskable one is taken. The maskable strobe of that cycle is lost.
- R8: `accept` is registered: it is high for exactly the one clock after the cycle in which a request is taken. A held-high `nmi_req` is taken only once. While `accept` is low, `action`, `target`, `push_pc` and `cycles` are all zero.
- R9: Reset (synchronous, active low) clears both flags and selects mode 0. `op_ei` sets both flags, `op_di` clears both, and `op_retn` copies the backup flag into the primary flag. When several of these coincide, disable beats enable and enable beats return.
- R10: `pv_flag` equals the backup enable flag while `op_ld_air` is high, and is 0 otherwise.
- R11: `op_im` with field `im_sel` loads the mode: values 0, 1, 4 and 5 give mode 0; 2 and 6 give mode 1; 3 and 7 give mode 2. A request taken in the same cycle still uses the old mode.
- R12: In a cycle where a request is taken, `op_ei`, `op_di` and `op_retn` have no effect on the enable flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, taken on its rising edge |
| int_req | input | 1 | Maskable request strobe |
| dev_byte | input | 8 | Byte supplied by the interrupting device |
| vec_base | input | 8 | Current vector-base register |
| op_ei | input | 1 | Enable-interrupts decode strobe |
| op_di | input | 1 | Disable-interrupts decode strobe |
| op_im | input | 1 | Set-mode decode strobe |
| im_sel | input | 3 | Mode field of the set-mode instruction |
| op_retn | input | 1 | Return-from-handler decode strobe |
| op_ld_air | input | 1 | Load-accumulator-from-vector/refresh strobe |
| pv_flag | output | 1 | Parity/overflow value for that load |
| accept | output | 1 | One-clock acceptance pulse |
| action | output | 2 | 00 execute byte, 01 restart, 10 vectored |
| target | output | 16 | Restart, vector or opcode address/value |
| push_pc | output | 1 | Core must push the PC |
| cycles | output | 5 | Machine-cycle cost of the response |

## Verification
Directed sequences set each mode through the set-mode strobe and then raise a maskable request. This separates the three response formats, and a sweep over all eight mode-field values separates the mode decode. Other directed cases place a non-maskable edge against a maskable request, a held non-maskable level, and enable/return strobes inside an acceptance cycle. The flags are read back through `pv_flag` and through whether a later maskable request is taken, which tells apart corruption of the primary flag and of the backup flag. Long runs of random requests and strobes then mix these cases with every possible flag state.

// File: rtl/int_accept_pkg.sv
// Shared types and helpers for the interrupt acceptance controller.
// Assumes the response mode field of the set-mode instruction is 3 bits wide.
package int_accept_pkg;

    // Response requested from the core
    typedef enum logic [1:0] {
        ACT_EXEC    = 2'b00,
        ACT_RESTART = 2'b01,
        ACT_VECTOR  = 2'b10
    } act_e;

    // Maskable response mode
    typedef enum logic [1:0] {
        MODE_EXEC  = 2'b00,
        MODE_FIXED = 2'b01,
        MODE_VECT  = 2'b10
    } imode_e;

    // Maps the set-mode field to a response mode (low two bits decide)
    function automatic imode_e decode_mode(input logic [2:0] sel);
        imode_e m;
        case (sel[1:0])
            2'b10:   m = MODE_FIXED;
            2'b11:   m = MODE_VECT;
            default: m = MODE_EXEC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/int_enable_ff.sv
// Primary and backup interrupt-enable flip-flops.
// Assumes at most one of take_nmi/take_int is high; acceptance overrides
// every decode strobe of the same cycle.
module int_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic take_nmi,
    input  logic take_int,
    input  logic set_en,
    input  logic clr_en,
    input  logic ret_nmi,
    output logic iff1,
    output logic iff2
);

    // Update both flags by priority: reset, acceptance, disable, enable, return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_nmi) begin
            iff1 <= 1'b0;
        end else if (take_int) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (clr_en) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (set_en) begin
            iff1 <= 1'b1;
            iff2 <= 1'b1;
        end else if (ret_nmi) begin
            iff1 <= iff2;
        end
    end

endmodule

// File: rtl/int_mode_reg.sv
// Response mode register, loaded from the set-mode instruction field.
// Assumes the field width given by SEL_W covers the decode helper input.
module int_mode_reg
    import int_accept_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output imode_e           mode
);

    // Hold mode; reset selects the execute-byte mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_EXEC;
        end else if (load) begin
            mode <= decode_mode(sel[2:0]);
        end
    end

endmodule

// File: rtl/int_resp_gen.sv
// Builds the registered response (accept, action, target, push, cost).
// Assumes take_nmi and take_int are mutually exclusive; all response
// fields are zero in any clock without acceptance.
module int_resp_gen
    import int_accept_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int CYC_W      = 5,
    parameter int NMI_ADDR   = 16'h0066,
    parameter int FIXED_ADDR = 16'h0038,
    parameter int RST_CYC    = 13,
    parameter int VEC_CYC    = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_nmi,
    input  logic              take_int,
    input  imode_e            mode,
    input  logic [DATA_W-1:0] dev_byte,
    input  logic [DATA_W-1:0] vec_base,
    output logic              accept,
    output logic [1:0]        action,
    output logic [ADDR_W-1:0] target,
    output logic              push_pc,
    output logic [CYC_W-1:0]  cycles
);

    localparam int PAD_W = ADDR_W - DATA_W;

    act_e              nxt_act;
    logic [ADDR_W-1:0] nxt_tgt;
    logic              nxt_push;
    logic [CYC_W-1:0]  nxt_cyc;

    // Select the response for this cycle's winning request
    always_comb begin
        nxt_act  = ACT_EXEC;
        nxt_tgt  = '0;
        nxt_push = 1'b0;
        nxt_cyc  = '0;
        if (take_nmi) begin
            nxt_act  = ACT_RESTART;
            nxt_tgt  = ADDR_W'(NMI_ADDR);
            nxt_push = 1'b1;
            nxt_cyc  = CYC_W'(RST_CYC);
        end else if (take_int) begin
            case (mode)
                MODE_FIXED: begin
                    nxt_act  = ACT_RESTART;
                    nxt_tgt  = ADDR_W'(FIXED_ADDR);
                    nxt_push = 1'b1;
                    nxt_cyc  = CYC_W'(RST_CYC);
                end
                MODE_VECT: begin
                    nxt_act  = ACT_VECTOR;
                    nxt_tgt  = {vec_base, dev_byte};
                    nxt_push = 1'b1;
                    nxt_cyc  = CYC_W'(VEC_CYC);
                end
                default: begin
                    nxt_act  = ACT_EXEC;
                    nxt_tgt  = {{PAD_W{1'b0}}, dev_byte};
                    nxt_push = 1'b0;
                    nxt_cyc  = '0;
                end
            endcase
        end
    end

    // Register the response so it appears as a one-clock pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept  <= 1'b0;
            action  <= 2'b00;
            target  <= '0;
            push_pc <= 1'b0;
            cycles  <= '0;
        end else begin
            accept  <= take_nmi | take_int;
            action  <= nxt_act;
            target  <= nxt_tgt;
            push_pc <= nxt_push;
            cycles  <= nxt_cyc;
        end
    end

endmodule

// File: rtl/int_accept_ctrl.sv
// Interrupt acceptance and mode controller (top).
// Detects the non-maskable edge, arbitrates it against the maskable
// request, and hands the winner to the response generator. Assumes the
// decode strobes are one-cycle pulses from the core's decoder.
module int_accept_ctrl
    import int_accept_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CYC_W      = 5,
    parameter int SEL_W      = 3,
    parameter int NMI_ADDR   = 16'h0066,
    parameter int FIXED_ADDR = 16'h0038,
    parameter int RST_CYC    = 13,
    parameter int VEC_CYC    = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_req,
    input  logic                int_req,
    input  logic [DATA_W-1:0]   dev_byte,
    input  logic [DATA_W-1:0]   vec_base,
    input  logic                op_ei,
    input  logic                op_di,
    input  logic                op_im,
    input  logic [SEL_W-1:0]    im_sel,
    input  logic                op_retn,
    input  logic                op_ld_air,
    output logic                pv_flag,
    output logic                accept,
    output logic [1:0]          action,
    output logic [2*DATA_W-1:0] target,
    output logic                push_pc,
    output logic [CYC_W-1:0]    cycles
);

    localparam int ADDR_W = 2 * DATA_W;

    logic   nmi_prev;
    logic   take_nmi;
    logic   take_int;
    logic   iff1;
    logic   iff2;
    imode_e mode;

    // Remember last non-maskable level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev <= 1'b0;
        else        nmi_prev <= nmi_req;
    end

    // Arbitrate: non-maskable edge first, maskable only when enabled
    always_comb begin
        take_nmi = nmi_req & ~nmi_prev;
        take_int = int_req & iff1 & ~take_nmi;
    end

    // Flag value reported by the load-from-vector/refresh instruction
    always_comb pv_flag = op_ld_air & iff2;

    int_enable_ff u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .set_en   (op_ei),
        .clr_en   (op_di),
        .ret_nmi  (op_retn),
        .iff1     (iff1),
        .iff2     (iff2)
    );

    int_mode_reg #(.SEL_W(SEL_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op_im),
        .sel   (im_sel),
        .mode  (mode)
    );

    int_resp_gen #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CYC_W      (CYC_W),
        .NMI_ADDR   (NMI_ADDR),
        .FIXED_ADDR (FIXED_ADDR),
        .RST_CYC    (RST_CYC),
        .VEC_CYC    (VEC_CYC)
    ) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .mode     (mode),
        .dev_byte (dev_byte),
        .vec_base (vec_base),
        .accept   (accept),
        .action   (action),
        .target   (target),
        .push_pc  (push_pc),
        .cycles   (cycles)
    );

endmodule

// File: rtl/int_accept_chk.sv
// Property checker for int_accept_ctrl, attached by bind.
// Assumes synchronous active-low reset; all properties are off in reset.
module int_accept_chk #(
    parameter int ADDR_W   = 16,
    parameter int CYC_W    = 5,
    parameter int NMI_ADDR = 16'h0066,
    parameter int RST_CYC  = 13,
    parameter int VEC_CYC  = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_req,
    input logic              op_ei,
    input logic              op_di,
    input logic              op_retn,
    input logic              take_nmi,
    input logic              take_int,
    input logic              iff1,
    input logic              iff2,
    input logic              accept,
    input logic [1:0]        action,
    input logic [ADDR_W-1:0] target,
    input logic              push_pc,
    input logic [CYC_W-1:0]  cycles
);

    a_r1_masked_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_nmi && !(int_req && iff1)) |=> !accept);

    a_r2_int_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (!iff1 && !iff2));

    a_r3_nmi_keeps_backup: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (accept && !iff1 && iff2 == $past(iff2)
                      && target == ADDR_W'(NMI_ADDR) && cycles == CYC_W'(RST_CYC)));

    a_r6_vector_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && action == 2'b10) |-> (push_pc && cycles == CYC_W'(VEC_CYC)));

    a_r7_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi && int_req) |=> (action == 2'b01 && target == ADDR_W'(NMI_ADDR)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !take_nmi && !take_int) |=> !accept);

    a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (op_retn && !op_ei && !op_di && !take_nmi && !take_int) |=> (iff1 == $past(iff2)));

endmodule

bind int_accept_ctrl int_accept_chk #(
    .ADDR_W   (ADDR_W),
    .CYC_W    (CYC_W),
    .NMI_ADDR (NMI_ADDR),
    .RST_CYC  (RST_CYC),
    .VEC_CYC  (VEC_CYC)
) u_int_accept_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_req  (int_req),
    .op_ei    (op_ei),
    .op_di    (op_di),
    .op_retn  (op_retn),
    .take_nmi (take_nmi),
    .take_int (take_int),
    .iff1     (iff1),
    .iff2     (iff2),
    .accept   (accept),
    .action   (action),
    .target   (target),
    .push_pc  (push_pc),
    .cycles   (cycles)
);

// File: tb/test_int_accept_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a bench-side model written from the requirements.
module test_int_accept_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi_req, int_req, op_ei, op_di, op_im, op_retn, op_ld_air;
    logic [7:0]  dev_byte, vec_base;
    logic [2:0]  im_sel;
    logic        pv_flag, accept, push_pc;
    logic [1:0]  action;
    logic [15:0] target;
    logic [4:0]  cycles;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string g_note = "";

    bit m_iff1, m_iff2, m_nprev;
    int m_mode;

    always #2.5 clk = ~clk;

    int_accept_ctrl i_int_accept_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .int_req(int_req),
        .dev_byte(dev_byte), .vec_base(vec_base), .op_ei(op_ei), .op_di(op_di),
        .op_im(op_im), .im_sel(im_sel), .op_retn(op_retn), .op_ld_air(op_ld_air),
        .pv_flag(pv_flag), .accept(accept), .action(action), .target(target),
        .push_pc(push_pc), .cycles(cycles)
    );

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s%s %s: actual 0x%0h expected 0x%0h", req, g_note, what, act, exp);
        end
    endtask

    function automatic int map_mode(input logic [2:0] y);
        if (y[1:0] == 2'b10) return 1;
        if (y[1:0] == 2'b11) return 2;
        return 0;
    endfunction

    // One clock: drive inputs, check pv, predict, then check the response
    task automatic cyc(input bit nmi, input bit irq, input logic [7:0] dev,
                       input logic [7:0] iv, input bit ei, input bit di,
                       input bit im, input logic [2:0] sel, input bit retn,
                       input bit ldair);
        bit          edge_n, ti, e_acc, e_push;
        logic [1:0]  e_act;
        logic [15:0] e_tgt;
        logic [4:0]  e_cyc;
        string       tag;
        nmi_req = nmi; int_req = irq; dev_byte = dev; vec_base = iv;
        op_ei = ei; op_di = di; op_im = im; im_sel = sel; op_retn = retn;
        op_ld_air = ldair;
        #1;
        chk_eq("R10", "pv_flag", pv_flag, 32'(ldair & m_iff2));
        edge_n = nmi && !m_nprev;
        ti     = irq && m_iff1 && !edge_n;
        e_acc = 1'b0; e_act = 2'b00; e_tgt = 16'h0; e_push = 1'b0; e_cyc = 5'd0;
        tag = irq ? "R1" : "R8";
        if (edge_n) begin
            e_acc = 1'b1; e_act = 2'b01; e_tgt = 16'h0066; e_push = 1'b1; e_cyc = 5'd13;
            tag = irq ? "R7" : "R3";
        end else if (ti) begin
            e_acc = 1'b1;
            if (m_mode == 1) begin
                e_act = 2'b01; e_tgt = 16'h0038; e_push = 1'b1; e_cyc = 5'd13; tag = "R5";
            end else if (m_mode == 2) begin
                e_act = 2'b10; e_tgt = {iv, dev}; e_push = 1'b1; e_cyc = 5'd19; tag = "R6";
            end else begin
                e_act = 2'b00; e_tgt = {8'h00, dev}; e_push = 1'b0; e_cyc = 5'd0; tag = "R4";
            end
        end
        if (edge_n)      m_iff1 = 1'b0;
        else if (ti)     begin m_iff1 = 1'b0; m_iff2 = 1'b0; end
        else if (di)     begin m_iff1 = 1'b0; m_iff2 = 1'b0; end
        else if (ei)     begin m_iff1 = 1'b1; m_iff2 = 1'b1; end
        else if (retn)   m_iff1 = m_iff2;
        if (im) m_mode = map_mode(sel);
        m_nprev = nmi;
        @(posedge clk);
        @(negedge clk);
        chk_eq(tag, "accept", 32'(accept), 32'(e_acc));
        chk_eq(tag, "action", 32'(action), 32'(e_act));
        chk_eq(tag, "target", 32'(target), 32'(e_tgt));
        chk_eq(tag, "push_pc", 32'(push_pc), 32'(e_push));
        chk_eq(tag, "cycles", 32'(cycles), 32'(e_cyc));
    endtask

    task automatic idle();
        cyc(0, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        nmi_req = 0; int_req = 0; dev_byte = 0; vec_base = 0; op_ei = 0;
        op_di = 0; op_im = 0; im_sel = 0; op_retn = 0; op_ld_air = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_iff1 = 0; m_iff2 = 0; m_nprev = 0; m_mode = 0;
        chk_eq("R9", "reset accept", 32'(accept), 32'd0);
        chk_eq("R9", "reset target", 32'(target), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R9: flags clear after reset
        g_note = "/R9";
        cyc(0, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 1);
        cyc(0, 1, 8'h11, 8'h00, 0, 0, 0, 3'd0, 0, 0);

        // R4: mode 0 after reset; R2: second request refused
        g_note = "/R2";
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 0, 3'd0, 0, 0);
        cyc(0, 1, 8'hC7, 8'h55, 0, 0, 0, 3'd0, 0, 0);
        cyc(0, 1, 8'hC7, 8'h55, 0, 0, 0, 3'd0, 0, 1);

        // R5: mode 1
        g_note = "/R11";
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 1, 3'd6, 0, 0);
        cyc(0, 1, 8'hFF, 8'h00, 0, 0, 0, 3'd0, 0, 0);

        // R6: mode 2 vectored
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 1, 3'd7, 0, 0);
        cyc(0, 1, 8'h3A, 8'h12, 0, 0, 0, 3'd0, 0, 0);

        // R3: NMI keeps backup flag; R9: return restores primary
        g_note = "/R9";
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 0, 3'd0, 0, 0);
        cyc(1, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 1);
        cyc(0, 1, 8'h20, 8'hAB, 0, 0, 0, 3'd0, 0, 1);
        cyc(0, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 1, 0);
        cyc(0, 1, 8'h20, 8'hAB, 0, 0, 0, 3'd0, 0, 0);

        // R7: simultaneous; R8: held NMI taken once
        g_note = "/R7";
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 0, 3'd0, 0, 0);
        cyc(1, 1, 8'h44, 8'h44, 0, 0, 0, 3'd0, 0, 0);
        g_note = "/R8";
        cyc(1, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 1);
        cyc(1, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 0);
        cyc(0, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 0);

        // R12: strobes ignored during acceptance; R11: old mode used
        g_note = "/R12";
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 0, 3'd0, 0, 0);
        cyc(0, 1, 8'h5E, 8'h66, 1, 0, 1, 3'd2, 1, 0);
        cyc(0, 0, 8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 1);
        cyc(0, 1, 8'h5E, 8'h66, 0, 0, 0, 3'd0, 0, 0);

        // R11: sweep of every mode field value
        g_note = "/R11";
        for (int y = 0; y < 8; y++) begin
            cyc(0, 0, 8'h00, 8'h00, 1, 0, 1, 3'(y), 0, 0);
            cyc(0, 1, 8'(8'h90 + y), 8'hE1, 0, 0, 0, 3'd0, 0, 0);
        end

        // Random traffic against the model
        g_note = "";
        for (int i = 0; i < 6000; i++) begin
            cyc(($urandom % 8) == 0, ($urandom % 3) == 0, 8'($urandom), 8'($urandom),
                ($urandom % 5) == 0, ($urandom % 11) == 0, ($urandom % 7) == 0,
                3'($urandom), ($urandom % 9) == 0, ($urandom % 4) == 0);
        end
        idle();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule